// File: doc/BRIEF.md
# Bus Monitor Packet Termination Controller

This block sits beside a bus monitor that records traffic into a circular stack in packets. It watches the monitor's message strobes, its recorded-word strobe and two timer ticks, together with the stack write pointer. From these it decides the cycle in which the packet being recorded must be closed. It emits one finalize strobe for that packet and latches the stack pointer as the start address of the next packet.

Most close causes are deferred. A word limit, an elapsed-time limit, a host stop request or a stack that is about to overrun the packet start each flag a pending close, and the packet ends when the current message ends. When no message is in progress the packet ends at once. A message-count limit closes the packet in the cycle of the message end that reaches it. An over-long idle gap closes the packet immediately.

Every cause also sets a sticky status bit. The status vector also carries a derived packet-ready bit, a stack-address-match bit and a fill-warning bit. The host clears status bits by writing ones, and an enable mask selects which bits drive the interrupt line.

Top module: `pkt_close_ctrl`

## Requirements
- R1: A recorded-word strobe that brings the packet's word count up to a nonzero `lim_words` sets status bit 1. The packet closes at the end of that message.
- R2: A message end that brings the packet's message count up to a nonzero `lim_msgs` sets status bit 2 and closes the packet in that same cycle.
- R3: While no message is in progress and the packet holds at least one message, gap ticks are counted. With a nonzero `lim_gap`, the tick that finds the count already equal to `lim_gap` (the gap has exceeded the limit) sets status bit 3 and closes the packet at once.
- R4: Time ticks are counted while a message is in progress or the packet holds a message. The tick that brings the count to a nonzero `lim_time` sets status bit 4. The close waits for the message in progress to end, or happens at once if the monitor is idle.
- R5: A `host_stop` pulse sets status bit 5. The packet closes at the end of the message in progress, or at once if the monitor is idle.
- R6: Let the remaining distance be (`pkt_start` − `stack_ptr`) mod 2^PTR_W. When it is nonzero and at most 64, status bit 0 is set and a close is deferred to the end of the message.
- R7: A close gives `pkt_done` high for exactly one cycle, in the cycle after the closing event, even when several causes coincide. At that point the counters restart, `pkt_start` takes the `stack_ptr` of the closing cycle, and no close happens while a message is in progress except at its end.
- R8: Status bit 6 (packet ready) reads as the OR of status bits 0 to 5.
- R9: Status bit 8 is set when `stack_ptr` equals `irq_addr`.
- R10: Status bit 9 is set when the remaining distance of R6 is nonzero and at most `fill_margin`.
- R11: Status bits are sticky. A cycle with `clr_stb` high clears the bits set in `clr_mask`, but a bit whose condition holds in that cycle stays set. Bits 7 and 10 to 15 read as zero.
- R12: `irq` is high when any bit of `status` AND `irq_en` is high.
- R13: After reset, `status` is zero, `pkt_done` is low and `pkt_start` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_start | input | 1 | First word of a bus message seen |
| msg_end | input | 1 | Bus message completed |
| word_stb | input | 1 | One bus word recorded in the packet |
| gap_tick | input | 1 | Gap timer resolution tick |
| time_tick | input | 1 | Packet timer resolution tick |
| host_stop | input | 1 | Host request to stop recording |
| stack_ptr | input | PTR_W | Current stack write address |
| lim_words | input | CNT_W | Word limit per packet, 0 disables |
| lim_msgs | input | CNT_W | Message limit per packet, 0 disables |
| lim_gap | input | CNT_W | Gap limit in ticks, 0 disables |
| lim_time | input | CNT_W | Packet time limit in ticks, 0 disables |
| irq_addr | input | PTR_W | Stack address that raises the match bit |
| fill_margin | input | PTR_W | Fill-warning distance in words |
| clr_stb | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 16 | Status bits to clear |
| irq_en | input | 16 | Interrupt enable mask |
| pkt_done | output | 1 | One-cycle packet finalize strobe |
| pkt_start | output | PTR_W | Start address of the open packet |
| status | output | 16 | Sticky status vector |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with PTR_W = 8 and CNT_W = 8. This gives a 256-word ring, so the fixed 64-word overflow window covers a quarter of the address space. Random pointer jumps and the fill margin therefore cross the distance thresholds often, and counter wrap at 256 is reachable. The limits are kept small (a few words, messages and ticks), so every close cause, and coincidences such as a host stop landing on a word-limit hit, occur many times in a few thousand cycles.

// File: rtl/pkt_close_pkg.sv
// Shared definitions for the packet termination controller.
// Assumes a 16-bit status vector with the bit map below.
package pkt_close_pkg;
    localparam int ST_W    = 16;
    localparam int B_OVF   = 0;
    localparam int B_WORDS = 1;
    localparam int B_MSGS  = 2;
    localparam int B_GAP   = 3;
    localparam int B_TIME  = 4;
    localparam int B_HOST  = 5;
    localparam int B_READY = 6;
    localparam int B_STKM  = 8;
    localparam int B_FILL  = 9;
    localparam int N_CAUSE = 6;

    // One-cycle condition hits raised by the detectors.
    typedef struct packed {
        logic fill;
        logic stkm;
        logic host;
        logic tmo;
        logic gap;
        logic msgs;
        logic words;
        logic ovf;
    } hit_t;
endpackage

// File: rtl/pkt_counters.sv
// Per-packet counters: words, messages, packet time and idle gap.
// Raises one-cycle hits when a programmed limit is reached.
// Assumes msg_start and msg_end never coincide; a zero limit disables its check.
module pkt_counters #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msg_start,
    input  logic             msg_end,
    input  logic             word_stb,
    input  logic             gap_tick,
    input  logic             time_tick,
    input  logic             fin,
    input  logic [CNT_W-1:0] lim_words,
    input  logic [CNT_W-1:0] lim_msgs,
    input  logic [CNT_W-1:0] lim_gap,
    input  logic [CNT_W-1:0] lim_time,
    output logic             in_msg,
    output logic             hit_words,
    output logic             hit_msgs,
    output logic             hit_gap,
    output logic             hit_time
);
    logic [CNT_W-1:0] word_cnt, msg_cnt, time_cnt, gap_cnt;
    logic             active;
    logic             has_msg;

    // Packet counts as started once a message is open or has been recorded.
    assign has_msg = (msg_cnt != '0);
    assign active  = in_msg | has_msg;

    // Limit comparisons against the count the current strobe will produce.
    always_comb begin
        hit_words = word_stb & in_msg & (lim_words != '0) &
                    (({1'b0, word_cnt} + 1'b1) == {1'b0, lim_words});
        hit_msgs  = msg_end & in_msg & (lim_msgs != '0) &
                    (({1'b0, msg_cnt} + 1'b1) == {1'b0, lim_msgs});
        hit_time  = time_tick & active & (lim_time != '0) &
                    ((time_cnt + 1'b1) == lim_time);
        hit_gap   = gap_tick & ~in_msg & has_msg & (lim_gap != '0) &
                    (gap_cnt == lim_gap);
    end

    // Message-in-progress flag.
    always_ff @(posedge clk) begin
        if (!rst_n)         in_msg <= 1'b0;
        else if (msg_start) in_msg <= 1'b1;
        else if (msg_end)   in_msg <= 1'b0;
    end

    // Word, message and time counters, cleared on packet close.
    always_ff @(posedge clk) begin
        if (!rst_n || fin) begin
            word_cnt <= '0;
            msg_cnt  <= '0;
            time_cnt <= '0;
        end else begin
            if (word_stb && in_msg) word_cnt <= word_cnt + 1'b1;
            if (msg_end && in_msg)  msg_cnt  <= msg_cnt + 1'b1;
            if (time_tick && active) time_cnt <= time_cnt + 1'b1;
        end
    end

    // Idle gap counter, restarted by each new message.
    always_ff @(posedge clk) begin
        if (!rst_n || fin)                    gap_cnt <= '0;
        else if (msg_start)                   gap_cnt <= '0;
        else if (gap_tick && !in_msg && has_msg) gap_cnt <= gap_cnt + 1'b1;
    end

    // R7
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> (msg_cnt == '0) && (word_cnt == '0) && (time_cnt == '0));
endmodule

// File: rtl/stack_watch.sv
// Tracks the packet start address and measures the ring distance from the
// stack pointer to it. Assumes OVF_MARGIN < 2**PTR_W; distance 0 means the
// packet is empty, not full.
module stack_watch #(
    parameter int PTR_W      = 10,
    parameter int OVF_MARGIN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fin,
    input  logic [PTR_W-1:0] stack_ptr,
    input  logic [PTR_W-1:0] irq_addr,
    input  logic [PTR_W-1:0] fill_margin,
    output logic [PTR_W-1:0] pkt_start,
    output logic             hit_ovf,
    output logic             hit_stkm,
    output logic             hit_fill
);
    localparam logic [PTR_W:0] MARGIN_V = (PTR_W+1)'(OVF_MARGIN);

    logic [PTR_W-1:0] remain;

    // Words left before the writer reaches the start address (mod ring size).
    always_comb begin
        remain   = pkt_start - stack_ptr;
        hit_ovf  = (remain != '0) && ({1'b0, remain} <= MARGIN_V);
        hit_fill = (remain != '0) && (remain <= fill_margin);
        hit_stkm = (stack_ptr == irq_addr);
    end

    // New packet begins where the writer stands when the old one closes.
    always_ff @(posedge clk) begin
        if (!rst_n)   pkt_start <= '0;
        else if (fin) pkt_start <= stack_ptr;
    end

    // R7
    start_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> (pkt_start == $past(stack_ptr)));
endmodule

// File: rtl/close_status.sv
// Decides the close cycle from the cause hits, emits the finalize strobe and
// keeps the sticky write-one-to-clear status vector and interrupt line.
// Assumes hits are single-cycle or level conditions sampled each cycle.
module close_status
    import pkt_close_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_msg,
    input  logic            msg_start,
    input  logic            msg_end,
    input  hit_t            hits,
    input  logic            clr_stb,
    input  logic [ST_W-1:0] clr_mask,
    input  logic [ST_W-1:0] irq_en,
    output logic            fin_now,
    output logic            pkt_done,
    output logic [ST_W-1:0] status,
    output logic            irq
);
    logic            pend_q;
    logic            defer_hit;
    logic            deferred;
    logic [ST_W-1:0] sts_q;
    logic [ST_W-1:0] set_v;
    logic [ST_W-1:0] clr_v;

    // Causes that wait for the end of the message in progress.
    assign defer_hit = hits.ovf | hits.words | hits.tmo | hits.host;
    assign deferred  = pend_q | defer_hit;

    // Close now on gap, at message end, or at once when idle.
    assign fin_now = hits.gap
                   | (in_msg & msg_end & (deferred | hits.msgs))
                   | (~in_msg & ~msg_start & deferred);

    // Pending close flag, dropped when the packet actually closes.
    always_ff @(posedge clk) begin
        if (!rst_n || fin_now) pend_q <= 1'b0;
        else if (defer_hit)    pend_q <= 1'b1;
    end

    // Registered single finalize strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) pkt_done <= 1'b0;
        else        pkt_done <= fin_now;
    end

    // Map hits onto their status positions.
    always_comb begin
        set_v          = '0;
        set_v[B_OVF]   = hits.ovf;
        set_v[B_WORDS] = hits.words;
        set_v[B_MSGS]  = hits.msgs;
        set_v[B_GAP]   = hits.gap;
        set_v[B_TIME]  = hits.tmo;
        set_v[B_HOST]  = hits.host;
        set_v[B_STKM]  = hits.stkm;
        set_v[B_FILL]  = hits.fill;
        clr_v          = clr_stb ? clr_mask : '0;
    end

    // Sticky status, a set in the same cycle outranks a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (sts_q & ~clr_v) | set_v;
    end

    // Ready bit derived from the cause bits, then interrupt reduction.
    always_comb begin
        status          = sts_q;
        status[B_READY] = |sts_q[N_CAUSE-1:0];
        irq             = |(status & irq_en);
    end

    // R11
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr_stb) |-> ((sts_q & $past(sts_q)) == $past(sts_q)));

    // R7
    defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_msg && !msg_end) |-> !fin_now);

    // R7
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> !pend_q);
endmodule

// File: rtl/pkt_close_ctrl.sv
// Top of the packet termination controller: counters, stack distance watch
// and close/status logic. Assumes one recorded word per word_stb and a
// ring buffer of 2**PTR_W words.
module pkt_close_ctrl
    import pkt_close_pkg::*;
#(
    parameter int PTR_W      = 10,
    parameter int CNT_W      = 16,
    parameter int OVF_MARGIN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             msg_start,
    input  logic             msg_end,
    input  logic             word_stb,
    input  logic             gap_tick,
    input  logic             time_tick,
    input  logic             host_stop,
    input  logic [PTR_W-1:0] stack_ptr,
    input  logic [CNT_W-1:0] lim_words,
    input  logic [CNT_W-1:0] lim_msgs,
    input  logic [CNT_W-1:0] lim_gap,
    input  logic [CNT_W-1:0] lim_time,
    input  logic [PTR_W-1:0] irq_addr,
    input  logic [PTR_W-1:0] fill_margin,
    input  logic             clr_stb,
    input  logic [ST_W-1:0]  clr_mask,
    input  logic [ST_W-1:0]  irq_en,
    output logic             pkt_done,
    output logic [PTR_W-1:0] pkt_start,
    output logic [ST_W-1:0]  status,
    output logic             irq
);
    hit_t hits;
    logic in_msg;
    logic fin_now;

    assign hits.host = host_stop;

    pkt_counters #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .msg_start (msg_start),
        .msg_end   (msg_end),
        .word_stb  (word_stb),
        .gap_tick  (gap_tick),
        .time_tick (time_tick),
        .fin       (fin_now),
        .lim_words (lim_words),
        .lim_msgs  (lim_msgs),
        .lim_gap   (lim_gap),
        .lim_time  (lim_time),
        .in_msg    (in_msg),
        .hit_words (hits.words),
        .hit_msgs  (hits.msgs),
        .hit_gap   (hits.gap),
        .hit_time  (hits.tmo)
    );

    stack_watch #(.PTR_W(PTR_W), .OVF_MARGIN(OVF_MARGIN)) u_stk (
        .clk         (clk),
        .rst_n       (rst_n),
        .fin         (fin_now),
        .stack_ptr   (stack_ptr),
        .irq_addr    (irq_addr),
        .fill_margin (fill_margin),
        .pkt_start   (pkt_start),
        .hit_ovf     (hits.ovf),
        .hit_stkm    (hits.stkm),
        .hit_fill    (hits.fill)
    );

    close_status u_sts (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_msg    (in_msg),
        .msg_start (msg_start),
        .msg_end   (msg_end),
        .hits      (hits),
        .clr_stb   (clr_stb),
        .clr_mask  (clr_mask),
        .irq_en    (irq_en),
        .fin_now   (fin_now),
        .pkt_done  (pkt_done),
        .status    (status),
        .irq       (irq)
    );
endmodule

// File: tb/sim_pkt_close_ctrl.sv
// Bench: directed corner cases, then seeded random traffic, all compared
// against a cycle model kept in bench variables.
module sim_pkt_close_ctrl;
    localparam int PW = 8;
    localparam int CW = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic          msg_start, msg_end, word_stb, gap_tick, time_tick, host_stop;
    logic [PW-1:0] stack_ptr, irq_addr, fill_margin;
    logic [CW-1:0] lim_words, lim_msgs, lim_gap, lim_time;
    logic          clr_stb;
    logic [15:0]   clr_mask, irq_en;
    logic          pkt_done, irq;
    logic [PW-1:0] pkt_start;
    logic [15:0]   status;

    pkt_close_ctrl #(.PTR_W(PW), .CNT_W(CW), .OVF_MARGIN(64)) u0 (
        .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .msg_end(msg_end),
        .word_stb(word_stb), .gap_tick(gap_tick), .time_tick(time_tick),
        .host_stop(host_stop), .stack_ptr(stack_ptr), .lim_words(lim_words),
        .lim_msgs(lim_msgs), .lim_gap(lim_gap), .lim_time(lim_time),
        .irq_addr(irq_addr), .fill_margin(fill_margin), .clr_stb(clr_stb),
        .clr_mask(clr_mask), .irq_en(irq_en), .pkt_done(pkt_done),
        .pkt_start(pkt_start), .status(status), .irq(irq)
    );

    int n_chk = 0;
    int n_err = 0;
    int ptr   = 0;
    // Model state.
    bit m_in = 0, m_pend = 0, exp_done = 0;
    int m_w = 0, m_m = 0, m_t = 0, m_g = 0, m_start = 0;
    logic [15:0] m_sts = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_status();
        logic [15:0] s = m_sts;
        s[6] = |m_sts[5:0];
        return s;
    endfunction

    // One clock of stimulus; the model advances alongside, outputs compared after the edge.
    task automatic step(input bit ms, me, ws, gt, tt, hs, cl, input logic [15:0] cm);
        int rem;
        bit act, hw, hm, ht, hg, ho, hf, hk, defr, fin;
        logic [15:0] setv;
        @(negedge clk);
        msg_start = ms; msg_end = me; word_stb = ws; gap_tick = gt;
        time_tick = tt; host_stop = hs; clr_stb = cl; clr_mask = cm;
        stack_ptr = ptr[PW-1:0];
        act = m_in || (m_m != 0);
        hw  = ws && m_in && lim_words != 0 && ((m_w + 1) & 255) == int'(lim_words);
        hm  = me && m_in && lim_msgs != 0 && ((m_m + 1) & 255) == int'(lim_msgs);
        ht  = tt && act && lim_time != 0 && ((m_t + 1) & 255) == int'(lim_time);
        hg  = gt && !m_in && m_m != 0 && lim_gap != 0 && m_g == int'(lim_gap);
        rem = (m_start - ptr) & 255;
        ho  = rem != 0 && rem <= 64;
        hf  = rem != 0 && rem <= int'(fill_margin);
        hk  = (ptr == int'(irq_addr));
        defr = m_pend || ho || hw || ht || hs;
        fin = hg || (m_in && me && (defr || hm)) || (!m_in && !ms && defr);
        setv = {6'b0, hf, hk, 2'b0, hs, ht, hg, hm, hw, ho};
        m_sts = (m_sts & ~(cl ? cm : 16'h0)) | setv;
        if (fin) m_g = 0;
        else if (ms) m_g = 0;
        else if (gt && !m_in && m_m != 0) m_g = m_g + 1;
        if (fin) begin
            m_w = 0; m_m = 0; m_t = 0; m_start = ptr; m_pend = 0;
        end else begin
            if (ws && m_in) m_w = (m_w + 1) & 255;
            if (me && m_in) m_m = (m_m + 1) & 255;
            if (tt && act)  m_t = (m_t + 1) & 255;
            if (ho || hw || ht || hs) m_pend = 1;
        end
        if (ms) m_in = 1; else if (me) m_in = 0;
        exp_done = fin;
        @(posedge clk); #1;
        chk("R7 finalize strobe", {31'b0, pkt_done}, {31'b0, exp_done});
        chk("R11 status vector", {16'b0, status}, {16'b0, exp_status()});
        chk("R12 irq", {31'b0, irq}, {31'b0, |(exp_status() & irq_en)});
        chk("R7 start address", {24'b0, pkt_start}, m_start);
        if (ws) ptr = (ptr + 1) & 255;
    endtask

    task automatic s(input bit ms, me, ws, gt, tt, hs);
        step(ms, me, ws, gt, tt, hs, 1'b0, 16'h0);
    endtask

    task automatic clr_all();
        step(0, 0, 0, 0, 0, 0, 1'b1, 16'hFFFF);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R7 watchdog act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0;
        msg_start = 0; msg_end = 0; word_stb = 0; gap_tick = 0; time_tick = 0;
        host_stop = 0; clr_stb = 0; clr_mask = '0; irq_en = '0;
        stack_ptr = '0; irq_addr = 8'd200; fill_margin = '0;
        lim_words = '0; lim_msgs = '0; lim_gap = '0; lim_time = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R13 reset state
        chk("R13 status after reset", {16'b0, status}, 32'h0);
        chk("R13 pkt_done after reset", {31'b0, pkt_done}, 32'h0);
        chk("R13 pkt_start after reset", {24'b0, pkt_start}, 32'h0);

        // R1 word limit, deferred to message end
        lim_words = 8'd3;
        s(1,0,0,0,0,0); s(0,0,1,0,0,0); s(0,0,1,0,0,0); s(0,0,1,0,0,0);
        chk("R1 words bit set", {31'b0, status[1]}, 32'h1);
        chk("R1 close deferred", {31'b0, pkt_done}, 32'h0);
        s(0,1,0,0,0,0);
        chk("R1 close at message end", {31'b0, pkt_done}, 32'h1);
        chk("R7 start latched", {24'b0, pkt_start}, 32'd3);
        s(0,0,0,0,0,0);
        chk("R7 single strobe", {31'b0, pkt_done}, 32'h0);
        clr_all();
        chk("R11 cleared", {16'b0, status}, 32'h0);
        lim_words = '0;

        // R2 message limit closes at the limiting message end
        lim_msgs = 8'd2;
        s(1,0,0,0,0,0); s(0,1,0,0,0,0);
        chk("R2 no close at first message", {31'b0, pkt_done}, 32'h0);
        s(1,0,0,0,0,0); s(0,1,0,0,0,0);
        chk("R2 close at second message", {31'b0, pkt_done}, 32'h1);
        chk("R2 msgs bit", {31'b0, status[2]}, 32'h1);
        clr_all(); lim_msgs = '0;

        // R3 gap limit closes at once
        lim_gap = 8'd2;
        s(1,0,0,0,0,0); s(0,1,0,0,0,0); s(0,0,0,1,0,0); s(0,0,0,1,0,0);
        chk("R3 not yet exceeded", {31'b0, pkt_done}, 32'h0);
        s(0,0,0,1,0,0);
        chk("R3 gap close", {31'b0, pkt_done}, 32'h1);
        chk("R3 gap bit", {31'b0, status[3]}, 32'h1);
        clr_all(); lim_gap = '0;

        // R4 time limit: deferred in a message, immediate when idle
        lim_time = 8'd2;
        s(0,0,0,0,1,0);
        chk("R4 empty packet ignores ticks", {16'b0, status}, 32'h0);
        s(1,0,0,0,0,0); s(0,0,0,0,1,0); s(0,0,0,0,1,0);
        chk("R4 time bit", {31'b0, status[4]}, 32'h1);
        chk("R4 deferred in message", {31'b0, pkt_done}, 32'h0);
        s(0,1,0,0,0,0);
        chk("R4 close at end", {31'b0, pkt_done}, 32'h1);
        clr_all();
        s(1,0,0,0,0,0); s(0,1,0,0,0,0); s(0,0,0,0,1,0); s(0,0,0,0,1,0);
        chk("R4 idle close", {31'b0, pkt_done}, 32'h1);
        clr_all(); lim_time = '0;

        // R5 host stop coinciding with a word limit hit
        lim_words = 8'd1;
        s(1,0,0,0,0,0); s(0,0,1,0,0,1);
        chk("R5 host bit", {31'b0, status[5]}, 32'h1);
        chk("R5 deferred", {31'b0, pkt_done}, 32'h0);
        s(0,1,0,0,0,0);
        chk("R5 close at end", {31'b0, pkt_done}, 32'h1);
        s(0,0,0,0,0,0);
        chk("R7 one strobe for two causes", {31'b0, pkt_done}, 32'h0);
        clr_all(); lim_words = '0;

        // R6 / R10 distance thresholds across the wrap
        fill_margin = 8'd100;
        s(1,0,0,0,0,0);
        ptr = (m_start - 101) & 255; s(0,0,0,0,0,0);
        chk("R10 fill clear at 101", {31'b0, status[9]}, 32'h0);
        ptr = (m_start - 100) & 255; s(0,0,0,0,0,0);
        chk("R10 fill set at 100", {31'b0, status[9]}, 32'h1);
        ptr = (m_start - 65) & 255; s(0,0,0,0,0,0);
        chk("R6 no overflow at 65", {31'b0, status[0]}, 32'h0);
        irq_en = 16'h0001;
        ptr = (m_start - 64) & 255; s(0,0,0,0,0,0);
        chk("R6 overflow at 64", {31'b0, status[0]}, 32'h1);
        chk("R8 ready", {31'b0, status[6]}, 32'h1);
        chk("R6 deferred", {31'b0, pkt_done}, 32'h0);
        chk("R12 irq enabled", {31'b0, irq}, 32'h1);
        irq_en = 16'h0100; s(0,0,0,0,0,0);
        chk("R12 irq masked", {31'b0, irq}, 32'h0);
        s(0,1,0,0,0,0);
        chk("R6 close at end", {31'b0, pkt_done}, 32'h1);

        // R9 match, R11 set outranks clear, reserved bits
        irq_addr = ptr[PW-1:0]; s(0,0,0,0,0,0);
        chk("R9 match bit", {31'b0, status[8]}, 32'h1);
        clr_all();
        chk("R11 set wins over clear", {31'b0, status[8]}, 32'h1);
        chk("R11 others cleared", {31'b0, status[0]}, 32'h0);
        chk("R8 ready follows causes", {31'b0, status[6]}, 32'h0);
        chk("R11 reserved zero", {16'b0, status & 16'hFC80}, 32'h0);
        chk("R12 irq on match", {31'b0, irq}, 32'h1);
        irq_addr = 8'd200; clr_all();
        irq_en = '0; fill_margin = '0;

        // Seeded random traffic
        for (int i = 0; i < 3000; i++) begin
            bit ms, me, ws, gt, tt, hs, cl;
            int r;
            logic [15:0] cm;
            if (i % 300 == 0) begin
                lim_words   = 8'($urandom % 12);
                lim_msgs    = 8'($urandom % 6);
                lim_gap     = 8'($urandom % 5);
                lim_time    = 8'($urandom % 8);
                fill_margin = 8'($urandom % 80);
                irq_addr    = 8'($urandom);
                irq_en      = 16'($urandom);
            end
            ms = 0; me = 0; ws = 0;
            r = int'($urandom % 100);
            if (m_in) begin
                if (r < 20) me = 1; else if (r < 70) ws = 1;
            end else if (r < 30) ms = 1;
            gt = ($urandom % 100) < 30;
            tt = ($urandom % 100) < 30;
            hs = ($urandom % 100) < 2;
            cl = ($urandom % 100) < 10;
            cm = 16'($urandom);
            if (($urandom % 100) < 2) ptr = int'($urandom % 256);
            step(ms, me, ws, gt, tt, hs, cl, cm);
        end

        summary();
        $finish;
    end
endmodule